// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block carries out one complete NAND flash operation from a few host-written registers. A host loads the address bytes, the data byte count and an optional confirm opcode. It then writes a packed control word whose top bit launches the operation. The sequencer drives a command-latch strobe with the first opcode. It follows with a counted run of address-latch strobes, then an optional write data phase fed from a byte source, and then the optional confirm opcode. It waits a fixed settling window, waits for the device to report ready, and finishes with an optional read data phase that delivers bytes to a sink.

Completion is reported through two write-one-to-clear interrupt flags, one for the whole operation and one for the data transfer. A busy bit protects a running operation: control words written while it is set have no effect. Strobe low and high widths and the settling window are fixed at build time as clock counts.

Register map (word index on `reg_addr`): 0 control, 1 confirm, 2 low address, 3 high address, 4 byte count, 5 interrupt flags, 6 state.

Top module: `nand_cmd_seq`

## Requirements
- R1: Writing the control register (index 0) with bit 31 set while idle starts an operation. Its first bus cycle is a command-latch strobe (CLE high, WE# pulsed) carrying control bits 7:0.
- R2: When control bit 30 is set, bits 29:27 hold the number of address cycles minus one, so 1 to 8 ALE strobes follow the first command. When bit 30 is clear, no ALE strobe is issued.
- R3: Address bytes go out in this order: register 2 bits 7:0, then bits 15:8, then register 3 bytes from bits 7:0 upward. Positions 6 and 7 send zero.
- R4: Control bit 25 requests a write phase. After the address cycles, exactly N bytes (N = register 4, not N minus one) are strobed out with WE#. Each byte is taken from `wsrc_data` in the cycle that `wsrc_take` is high.
- R5: Control bit 26 with bit 25 clear requests a read phase of exactly N RE# strobes. Each sampled byte is presented on `rsink_data` with `rsink_valid` for one cycle. With N equal to 0 there is no data phase.
- R6: Register 1 bit 8 enables a second command-latch strobe carrying register 1 bits 7:0. It is issued after the address and write phases and before any read phase.
- R7: Control bit 19 selects chip enable 1 (`nand_ce_n` = 01) when set and chip enable 0 (`nand_ce_n` = 10) when clear. The selected enable is held low for the whole operation and both are high when idle.
- R8: After the last WE# strobe, the sequencer waits T_WB clocks and then waits for `nand_rb` high. No RE# strobe occurs before both have happened.
- R9: Interrupt register (index 5) bit 31 is set when an operation ends. Bit 28 is set when a data phase with N > 0 completes. Writing a one clears a bit. A set and a clear in the same cycle leave the bit set, and `irq` is high while either bit is set.
- R10: State register (index 6) bit 0 reads 1 from the cycle after the start until the operation ends. A control write while busy starts nothing and leaves the stored control word unchanged.
- R11: After reset both chip enables, WE# and RE# are high, CLE, ALE and the output enable are low, and the interrupt and state registers read zero.

Port notes: each strobe is held low for T_LOW clocks and high for T_HIGH clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | High while any interrupt flag is set |
| nand_ce_n | output | 2 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Byte driven onto the flash I/O |
| nand_io_oe | output | 1 | Output enable for the flash I/O |
| nand_io_in | input | 8 | Byte read from the flash I/O |
| nand_rb | input | 1 | Ready (high) / busy (low) from the device |
| wsrc_take | output | 1 | Consumes the current write byte |
| wsrc_data | input | 8 | Current write byte from the buffer |
| rsink_valid | output | 1 | Read byte valid |
| rsink_data | output | 8 | Read byte to the buffer |

## Verification
The end of an operation, which sets interrupt bit 31, can fall in the same cycle as a host write that clears that bit. The bench provokes this by holding a clear write on the interrupt register in every cycle of a read operation. It stops the writes in the first cycle it sees bit 31 read back as one. The flag must have survived its coincidence with a clear, and it must still read one a cycle later. A second pairing, a control write landing while busy, is judged from the flash bus log: only one command strobe sequence may appear, and the stored control word must stay unchanged.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    // Register word indices
    localparam logic [2:0] RA_CTRL    = 3'd0;
    localparam logic [2:0] RA_CONFIRM = 3'd1;
    localparam logic [2:0] RA_ADDR_LO = 3'd2;
    localparam logic [2:0] RA_ADDR_HI = 3'd3;
    localparam logic [2:0] RA_LEN     = 3'd4;
    localparam logic [2:0] RA_IRQ     = 3'd5;
    localparam logic [2:0] RA_STATE   = 3'd6;

    // Control word bit positions
    localparam int CB_GO    = 31;
    localparam int CB_AMARK = 30;
    localparam int CB_RD    = 26;
    localparam int CB_WR    = 25;
    localparam int CB_CS    = 19;
    localparam int CF_EN    = 8;

    // Interrupt flag positions
    localparam int IB_CMD  = 31;
    localparam int IB_DATA = 28;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2,
        ST_TWB, ST_WAITRB, ST_RDATA, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [3:0]  naddr;
        logic        cs;
        logic        op2_en;
        logic [7:0]  op2;
        logic [15:0] addr_lo;
        logic [31:0] addr_hi;
    } op_cfg_t;

    function automatic logic [3:0] addr_count(input logic [31:0] w);
        return w[CB_AMARK] ? ({1'b0, w[29:27]} + 4'd1) : 4'd0;
    endfunction

    function automatic logic [7:0] addr_byte(input op_cfg_t c, input logic [2:0] k);
        logic [7:0] b;
        case (k)
            3'd0:    b = c.addr_lo[7:0];
            3'd1:    b = c.addr_lo[15:8];
            3'd2:    b = c.addr_hi[7:0];
            3'd3:    b = c.addr_hi[15:8];
            3'd4:    b = c.addr_hi[23:16];
            3'd5:    b = c.addr_hi[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/nseq_regs.sv
module nseq_regs
    import nseq_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             busy_i,
    input  logic             op_done_i,
    input  logic             data_done_i,
    output logic             start_o,
    output logic [7:0]       op1_o,
    output op_cfg_t          cfg_o,
    output logic [LEN_W-1:0] len_o,
    output logic             irq_o
);

    logic [31:0]      ctrl_q;
    logic [8:0]       conf_q;
    logic [15:0]      alo_q;
    logic [31:0]      ahi_q;
    logic [LEN_W-1:0] len_q;
    logic             irq_cmd_q;
    logic             irq_dat_q;
    logic             wr_irq;

    assign start_o = reg_we && (reg_addr == RA_CTRL) && reg_wdata[CB_GO] && !busy_i;
    assign wr_irq  = reg_we && (reg_addr == RA_IRQ);

    // The operation is described by the word being written plus the staged registers
    assign op1_o         = reg_wdata[7:0];
    assign cfg_o.rd      = reg_wdata[CB_RD];
    assign cfg_o.wr      = reg_wdata[CB_WR];
    assign cfg_o.naddr   = addr_count(reg_wdata);
    assign cfg_o.cs      = reg_wdata[CB_CS];
    assign cfg_o.op2_en  = conf_q[CF_EN];
    assign cfg_o.op2     = conf_q[7:0];
    assign cfg_o.addr_lo = alo_q;
    assign cfg_o.addr_hi = ahi_q;
    assign len_o         = len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            conf_q    <= '0;
            alo_q     <= '0;
            ahi_q     <= '0;
            len_q     <= '0;
            irq_cmd_q <= 1'b0;
            irq_dat_q <= 1'b0;
        end else begin
            if (start_o) ctrl_q <= reg_wdata;
            if (reg_we && reg_addr == RA_CONFIRM) conf_q <= reg_wdata[8:0];
            if (reg_we && reg_addr == RA_ADDR_LO) alo_q  <= reg_wdata[15:0];
            if (reg_we && reg_addr == RA_ADDR_HI) ahi_q  <= reg_wdata;
            if (reg_we && reg_addr == RA_LEN)     len_q  <= reg_wdata[LEN_W-1:0];
            // set has priority over a clear in the same cycle
            irq_cmd_q <= op_done_i   | (irq_cmd_q & ~(wr_irq & reg_wdata[IB_CMD]));
            irq_dat_q <= data_done_i | (irq_dat_q & ~(wr_irq & reg_wdata[IB_DATA]));
        end
    end

    assign irq_o = irq_cmd_q | irq_dat_q;

    always_comb begin
        case (reg_addr)
            RA_CTRL:    reg_rdata = ctrl_q;
            RA_CONFIRM: reg_rdata = {23'd0, conf_q};
            RA_ADDR_LO: reg_rdata = {16'd0, alo_q};
            RA_ADDR_HI: reg_rdata = ahi_q;
            RA_LEN:     reg_rdata = 32'(len_q);
            RA_IRQ:     reg_rdata = {irq_cmd_q, 2'b00, irq_dat_q, 28'd0};
            RA_STATE:   reg_rdata = {31'd0, busy_i};
            default:    reg_rdata = 32'd0;
        endcase
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_o |=> busy_i);                                                // R10
    AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_i && reg_we && reg_addr == RA_CTRL) |=> $stable(ctrl_q));   // R10
    AST_END_FLAGS_CMD: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_i) |-> irq_cmd_q);                                      // R9

endmodule

// File: rtl/nseq_engine.sv
module nseq_engine
    import nseq_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int T_LOW  = 2,
    parameter int T_HIGH = 2,
    parameter int T_WB   = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [7:0]       op1_i,
    input  op_cfg_t          cfg_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             busy_o,
    output logic             op_done_o,
    output logic             data_done_o,
    output logic [1:0]       nand_ce_n_o,
    output logic             nand_cle_o,
    output logic             nand_ale_o,
    output logic             nand_we_n_o,
    output logic             nand_re_n_o,
    output logic [7:0]       nand_io_out_o,
    output logic             nand_io_oe_o,
    input  logic [7:0]       nand_io_in_i,
    input  logic             nand_rb_i,
    output logic             wsrc_take_o,
    input  logic [7:0]       wsrc_data_i,
    output logic             rsink_valid_o,
    output logic [7:0]       rsink_data_o
);

    localparam int TM0  = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
    localparam int TMAX = (TM0 > T_WB) ? TM0 : T_WB;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int IW1  = LEN_W + 1;

    seq_state_e       st_q, st_n;
    logic             ph_q, ph_n;       // 0: strobe low, 1: strobe high
    logic [TW-1:0]    tmr_q, tmr_n;
    logic [LEN_W-1:0] idx_q, idx_n;
    logic [7:0]       io_q, io_n;
    op_cfg_t          cfg_q;
    logic [LEN_W-1:0] len_q;

    logic take, rstrobe, ddone, odone;
    logic bus_end, to_post_addr, to_post_wr;
    logic do_wr, do_rd, more_addr, more_data, drive;

    assign do_wr     = cfg_q.wr && (len_q != '0);
    assign do_rd     = cfg_q.rd && !cfg_q.wr && (len_q != '0);
    assign more_addr = ({1'b0, idx_q} + 1'b1) < IW1'(cfg_q.naddr);
    assign more_data = ({1'b0, idx_q} + 1'b1) < {1'b0, len_q};

    always_comb begin
        st_n = st_q; ph_n = ph_q; tmr_n = tmr_q; idx_n = idx_q; io_n = io_q;
        take = 1'b0; rstrobe = 1'b0; ddone = 1'b0; odone = 1'b0;
        bus_end = 1'b0; to_post_addr = 1'b0; to_post_wr = 1'b0;
        case (st_q)
            ST_IDLE: if (start_i) begin
                st_n = ST_CMD1; io_n = op1_i; ph_n = 1'b0; tmr_n = '0;
            end
            ST_CMD1, ST_ADDR, ST_WDATA, ST_CMD2, ST_RDATA: begin
                if (!ph_q) begin
                    if (tmr_q == TW'(T_LOW - 1)) begin
                        ph_n = 1'b1; tmr_n = '0; rstrobe = (st_q == ST_RDATA);
                    end else tmr_n = tmr_q + 1'b1;
                end else if (tmr_q != TW'(T_HIGH - 1)) tmr_n = tmr_q + 1'b1;
                else bus_end = 1'b1;
            end
            ST_TWB: if (tmr_q == TW'(T_WB - 1)) begin
                st_n = ST_WAITRB; tmr_n = '0;
            end else tmr_n = tmr_q + 1'b1;
            ST_WAITRB: if (nand_rb_i) begin
                if (do_rd) begin
                    st_n = ST_RDATA; idx_n = '0; ph_n = 1'b0; tmr_n = '0;
                end else st_n = ST_DONE;
            end
            ST_DONE: begin odone = 1'b1; st_n = ST_IDLE; end
            default: st_n = ST_IDLE;
        endcase

        if (bus_end) begin
            ph_n = 1'b0; tmr_n = '0;
            case (st_q)
                ST_CMD1: if (cfg_q.naddr != 4'd0) begin
                    st_n = ST_ADDR; idx_n = '0; io_n = addr_byte(cfg_q, 3'd0);
                end else to_post_addr = 1'b1;
                ST_ADDR: if (more_addr) begin
                    idx_n = idx_q + 1'b1; io_n = addr_byte(cfg_q, idx_q[2:0] + 3'd1);
                end else to_post_addr = 1'b1;
                ST_WDATA: if (more_data) begin
                    idx_n = idx_q + 1'b1; io_n = wsrc_data_i; take = 1'b1;
                end else begin
                    ddone = 1'b1; to_post_wr = 1'b1;
                end
                ST_CMD2: st_n = ST_TWB;
                ST_RDATA: if (more_data) idx_n = idx_q + 1'b1;
                else begin
                    ddone = 1'b1; st_n = ST_DONE;
                end
                default: ;
            endcase
        end

        if (to_post_addr) begin
            if (do_wr) begin
                st_n = ST_WDATA; idx_n = '0; io_n = wsrc_data_i; take = 1'b1;
            end else to_post_wr = 1'b1;
        end
        if (to_post_wr) begin
            if (cfg_q.op2_en) begin
                st_n = ST_CMD2; io_n = cfg_q.op2;
            end else st_n = ST_TWB;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ph_q  <= 1'b0;
            tmr_q <= '0;
            idx_q <= '0;
            io_q  <= '0;
            cfg_q <= '0;
            len_q <= '0;
        end else begin
            st_q  <= st_n;
            ph_q  <= ph_n;
            tmr_q <= tmr_n;
            idx_q <= idx_n;
            io_q  <= io_n;
            if (st_q == ST_IDLE && start_i) begin
                cfg_q <= cfg_i;
                len_q <= len_i;
            end
        end
    end

    assign drive         = (st_q == ST_CMD1) || (st_q == ST_ADDR) ||
                           (st_q == ST_WDATA) || (st_q == ST_CMD2);
    assign busy_o        = (st_q != ST_IDLE);
    assign nand_cle_o    = (st_q == ST_CMD1) || (st_q == ST_CMD2);
    assign nand_ale_o    = (st_q == ST_ADDR);
    assign nand_we_n_o   = !(drive && !ph_q);
    assign nand_re_n_o   = !((st_q == ST_RDATA) && !ph_q);
    assign nand_io_oe_o  = drive;
    assign nand_io_out_o = io_q;
    assign nand_ce_n_o   = !busy_o ? 2'b11 : (cfg_q.cs ? 2'b01 : 2'b10);
    assign wsrc_take_o   = take;
    assign rsink_valid_o = rstrobe;
    assign rsink_data_o  = nand_io_in_i;
    assign data_done_o   = ddone;
    assign op_done_o     = odone;

    AST_READY_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n_o |-> nand_rb_i);                                       // R8
    AST_CE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(nand_ce_n_o));              // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n_o && !nand_re_n_o));                                  // R5

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nseq_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int T_LOW  = 2,
    parameter int T_HIGH = 2,
    parameter int T_WB   = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic [1:0]  nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rb,
    output logic        wsrc_take,
    input  logic [7:0]  wsrc_data,
    output logic        rsink_valid,
    output logic [7:0]  rsink_data
);

    logic             busy, op_done, data_done, start;
    logic [7:0]       op1;
    op_cfg_t          cfg;
    logic [LEN_W-1:0] len;

    nseq_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .op_done_i(op_done), .data_done_i(data_done),
        .start_o(start), .op1_o(op1), .cfg_o(cfg), .len_o(len), .irq_o(irq)
    );

    nseq_engine #(.LEN_W(LEN_W), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_WB(T_WB)) u_engine (
        .clk(clk), .rst(rst),
        .start_i(start), .op1_i(op1), .cfg_i(cfg), .len_i(len),
        .busy_o(busy), .op_done_o(op_done), .data_done_o(data_done),
        .nand_ce_n_o(nand_ce_n), .nand_cle_o(nand_cle), .nand_ale_o(nand_ale),
        .nand_we_n_o(nand_we_n), .nand_re_n_o(nand_re_n),
        .nand_io_out_o(nand_io_out), .nand_io_oe_o(nand_io_oe),
        .nand_io_in_i(nand_io_in), .nand_rb_i(nand_rb),
        .wsrc_take_o(wsrc_take), .wsrc_data_i(wsrc_data),
        .rsink_valid_o(rsink_valid), .rsink_data_o(rsink_data)
    );

endmodule

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;

    localparam int T_LOW    = 2;
    localparam int T_HIGH   = 1;
    localparam int T_WB     = 6;
    localparam int BUSY_LEN = 15;
    localparam logic [7:0] OP_CONF = 8'h30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [1:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb = 1'b1;
    logic        wsrc_take, rsink_valid;
    logic [7:0]  wsrc_data, rsink_data;

    always #2.5 clk = ~clk;

    nand_cmd_seq #(.LEN_W(12), .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_WB(T_WB)) u_nand_cmd_seq (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
        .nand_rb(nand_rb), .wsrc_take(wsrc_take), .wsrc_data(wsrc_data),
        .rsink_valid(rsink_valid), .rsink_data(rsink_data)
    );

    int errors = 0;
    int checks = 0;

    // bus monitor state (written only by the monitor)
    int op_id = 0, seen_id = 0;
    int nlog, nrd, ntake, widx, rcnt, busy_cnt, since_we;
    bit ce_bad, rdy_bad, tk_prev;
    bit prev_we = 1'b1, prev_re = 1'b1;
    logic       lg_cle [64];
    logic       lg_ale [64];
    logic [7:0] lg_io  [64];
    logic [7:0] rd_log [64];
    logic [1:0] exp_ce = 2'b11;

    function automatic logic [7:0] wpat(input int j);
        return 8'hA5 ^ 8'(j * 7);
    endfunction
    function automatic logic [7:0] rpat(input int j);
        return 8'h3C + 8'(j * 5);
    endfunction

    assign wsrc_data  = wpat(widx);
    assign nand_io_in = rpat(rcnt);

    always @(negedge clk) begin
        if (op_id != seen_id) begin
            seen_id = op_id; nlog = 0; nrd = 0; ntake = 0; widx = 0; rcnt = 0;
            ce_bad = 0; rdy_bad = 0; tk_prev = 0; since_we = 0;
        end else begin
            if (tk_prev) widx = widx + 1;
            tk_prev = wsrc_take;
            if (wsrc_take) ntake = ntake + 1;
            if (rsink_valid) begin
                if (nrd < 64) rd_log[nrd] = rsink_data;
                nrd = nrd + 1;
            end
            if (prev_re && !nand_re_n) begin
                if (!nand_rb || since_we < T_WB) rdy_bad = 1;
            end
            if (!prev_re && nand_re_n) rcnt = rcnt + 1;
            since_we = since_we + 1;
            if (!prev_we && nand_we_n) begin
                if (nlog < 64) begin
                    lg_cle[nlog] = nand_cle; lg_ale[nlog] = nand_ale; lg_io[nlog] = nand_io_out;
                end
                nlog = nlog + 1;
                since_we = 0;
                if (nand_ce_n != exp_ce) ce_bad = 1;
            end
        end
        if (!prev_we && nand_we_n && nand_cle && nand_io_out == OP_CONF) busy_cnt = BUSY_LEN;
        else if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
        nand_rb = (busy_cnt == 0);
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        rd(3'd6, s);
        while (s[0] && n < 5000) begin
            rd(3'd6, s);
            n++;
        end
        if (n >= 5000) chk(1'b0, "R10 busy never cleared", s, 0);
    endtask

    function automatic logic [7:0] abyte(input logic [15:0] lo, input logic [31:0] hi, input int k);
        if (k == 0) return lo[7:0];
        if (k == 1) return lo[15:8];
        if (k < 6) return hi[8*(k-2) +: 8];
        return 8'h00;
    endfunction

    function automatic logic [31:0] mk_ctrl(input int na, input int dir, input bit cs, input logic [7:0] op1);
        logic [31:0] c = 32'd0;
        c[31] = 1'b1;
        if (na != 0) begin
            c[30] = 1'b1;
            c[29:27] = 3'(na - 1);
        end
        c[26] = (dir == 1);
        c[25] = (dir == 2);
        c[19] = cs;
        c[7:0] = op1;
        return c;
    endfunction

    // Launch one operation; optionally collide a second control write with it
    task automatic run_op(input int na, input int dir, input bit c2, input int ln,
                          input bit cs, input bit collide);
        logic [7:0]  op1 = 8'h60 + 8'(na * 2) + 8'(dir);
        logic [15:0] alo = 16'hB1C2 ^ 16'(na);
        logic [31:0] ahi = 32'h4D5E6F70 + 32'(na);
        logic [31:0] ctl, r;
        int e1, e2, e3, e4, e6, nale, nexp, base;
        wr(3'd2, {16'd0, alo});
        wr(3'd3, ahi);
        wr(3'd4, 32'(ln));
        wr(3'd1, {23'd0, c2, OP_CONF});
        ctl = mk_ctrl(na, dir, cs, op1);
        exp_ce = cs ? 2'b01 : 2'b10;
        op_id = op_id + 1;
        wr(3'd0, ctl);
        if (collide) begin
            rd(3'd6, r);
            chk(r[0] == 1'b1, "R10 busy during operation", r[0], 1);
            wr(3'd0, mk_ctrl(1, 0, !cs, 8'h55));
        end
        wait_idle();
        @(negedge clk);
        // expected strobe sequence
        e1 = 0; e2 = 0; e4 = 0; e6 = 0; nale = 0;
        nexp = 1 + na + ((dir == 2) ? ln : 0) + (c2 ? 1 : 0);
        if (!(lg_cle[0] == 1'b1 && lg_ale[0] == 1'b0 && lg_io[0] == op1)) e1 = 1;
        for (int i = 0; i < nlog && i < 64; i++) if (lg_ale[i]) nale++;
        for (int k = 0; k < na; k++)
            if (!(lg_ale[1+k] == 1'b1 && lg_cle[1+k] == 1'b0 && lg_io[1+k] == abyte(alo, ahi, k))) e2++;
        base = 1 + na;
        if (dir == 2)
            for (int j = 0; j < ln; j++)
                if (!(lg_ale[base+j] == 1'b0 && lg_cle[base+j] == 1'b0 && lg_io[base+j] == wpat(j))) e4++;
        if (c2) begin
            e3 = nexp - 1;
            if (!(lg_cle[e3] == 1'b1 && lg_io[e3] == OP_CONF)) e6 = 1;
        end
        chk(e1 == 0, "R1 first command strobe", lg_io[0], op1);
        chk(nale == na, "R2 address cycle count", nale, na);
        chk(e2 == 0, "R3 address byte order", e2, 0);
        chk(e4 == 0 && ntake == ((dir == 2) ? ln : 0), "R4 write bytes", ntake, (dir == 2) ? ln : 0);
        chk(e6 == 0 && nlog == nexp, "R6 confirm placement and strobe total", nlog, nexp);
        chk(nrd == ((dir == 1) ? ln : 0), "R5 read byte count", nrd, (dir == 1) ? ln : 0);
        for (int j = 0; j < nrd && j < 64; j++)
            if (rd_log[j] != rpat(j)) chk(1'b0, "R5 read byte value", rd_log[j], rpat(j));
        chk(!ce_bad, "R7 chip enable", nand_ce_n, exp_ce);
        if (dir == 1 && ln > 0) chk(!rdy_bad, "R8 read before tWB and ready", rdy_bad, 0);
        rd(3'd5, r);
        chk(r[31] == 1'b1 && r[28] == ((dir != 0) && (ln != 0)), "R9 flags after operation",
            {r[31], r[28]}, {1'b1, (dir != 0) && (ln != 0)});
        if (collide) begin
            rd(3'd0, r);
            chk(r == ctl, "R10 control word kept while busy", r, ctl);
        end
        wr(3'd5, 32'h9000_0000);
        rd(3'd5, r);
        chk(r == 32'd0 && !irq, "R9 write-one clear", r, 0);
    endtask

    initial begin
        logic [31:0] r;
        int n;
        bit seen;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(nand_ce_n == 2'b11 && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
            "R11 pins after reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe},
            7'b1111000);
        rd(3'd5, r);
        chk(r == 32'd0 && !irq, "R11 flags after reset", r, 0);
        rd(3'd6, r);
        chk(r == 32'd0, "R11 state after reset", r, 0);

        for (int na = 0; na <= 8; na++)
            for (int dir = 0; dir < 3; dir++)
                for (int c2 = 0; c2 < 2; c2++)
                    for (int li = 0; li < 3; li++) begin
                        int ln = (li == 0) ? 0 : (li == 1) ? 1 : 3;
                        if (dir != 0 || li == 0)
                            run_op(na, dir, c2[0], ln, bit'((na + li) & 1), 1'b0);
                    end

        // control word written while busy
        run_op(3, 2, 1'b1, 3, 1'b0, 1'b1);
        run_op(1, 1, 1'b1, 2, 1'b1, 1'b1);

        // completion coinciding with a clear of the same flag
        wr(3'd2, 32'h0000_1234);
        wr(3'd4, 32'd2);
        wr(3'd1, 32'd0);
        op_id = op_id + 1;
        exp_ce = 2'b10;
        wr(3'd0, mk_ctrl(1, 1, 1'b0, 8'h70));
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h9000_0000;
        seen = 0; n = 0;
        while (!seen && n < 3000) begin
            @(negedge clk);
            #1;
            if (reg_rdata[31]) begin seen = 1; reg_we = 1'b0; end
            n++;
        end
        reg_we = 1'b0;
        chk(seen, "R9 set beats same-cycle clear", seen, 1);
        rd(3'd5, r);
        chk(r[31] == 1'b1 && irq, "R9 flag held after race", r[31], 1);
        wr(3'd5, 32'h9000_0000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule